// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This unit is a one-stage datapath for scalar bit tricks on 32-bit or 64-bit operands. A 3-bit select chooses the operation:

- and-not;
- bit-field extract;
- isolate the lowest set bit;
- mask up to and including the lowest set bit;
- clear the lowest set bit;
- trailing-zero count.

A width-mode bit restricts the operation to the low 32 bits of the operands. The result is registered together with a valid flag.

An execution pipeline presents both operands, the select and the mode bit with `in_valid` high. Exactly one clock later it reads `result` while `out_valid` is high.

The extract operation takes its start index and field length packed into the second operand. It is not given separate shift and mask inputs.

Top module: `bitmanip_unit`

## Requirements
- R1: With select code 0, the result is the bitwise complement of operand A ANDed with operand B.
- R2: With select code 1, the result is a field of operand A. The field starts at bit index B[7:0] and is B[15:8] bits long, placed at result bit 0. Result bits above the field length are zero. Bits of B above bit 15 have no effect.
- R3: For extract, when B[7:0] is greater than or equal to the active width (32 or 64), the result is zero.
- R4: For extract, when start plus length passes the active width, the field stops at the top bit of the operand. When the length is at least the active width, every remaining bit above the start is kept.
- R5: With select code 2, the result holds only the lowest set bit of A. A zero operand gives zero.
- R6: With select code 3, the result has ones from bit 0 up to and including the lowest set bit of A. A zero operand gives all ones at the active width.
- R7: With select code 4, the result is A with its lowest set bit cleared. A zero operand gives zero.
- R8: With select code 5, the result is the number of consecutive zero bits of A counted upward from bit 0. A zero operand gives the active width, 32 or 64.
- R9: Select codes 6 and 7 give a zero result.
- R10: When `narrow` is 1, operand bits 63:32 have no effect and result bits 63:32 are zero for every operation.
- R11: `result` and `out_valid` change on the rising clock edge, one cycle after `in_valid`. While `in_valid` is low, `out_valid` drops and `result` keeps its last value.
- R12: A synchronous active-high `rst` clears `out_valid` and `result`. It takes priority over an `in_valid` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and select are valid this cycle |
| op_sel | input | 3 | Operation code, 0 to 7 |
| narrow | input | 1 | 1 selects 32-bit mode, 0 selects 64-bit mode |
| opnd_a | input | 64 | Source operand |
| opnd_b | input | 64 | Second operand: and-not mask, or extract control |
| result | output | 64 | Registered result |
| out_valid | output | 1 | Result is valid |

## Verification
Two functions of this block can fall in the same cycle: the synchronous reset and the capture of a new operation. The bench provokes this by raising `rst` while `in_valid` is high with a nonzero-producing operand. One edge later it judges that `out_valid` is low and `result` is zero.

A second overlap comes from the width mode acting on every operation. Random operands carry dirty upper halves in 32-bit mode. Each result is compared with a bench model that first discards those bits.

// File: rtl/bitmanip_unit.sv
module bitmanip_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [2:0]      op_sel,
  input  logic            narrow,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  output logic [XLEN-1:0] result,
  output logic            out_valid
);
  localparam int HALF = XLEN / 2;
  localparam int CW   = $clog2(XLEN + 1);

  localparam logic [2:0] OP_ANDNOT = 3'd0;
  localparam logic [2:0] OP_FIELD  = 3'd1;
  localparam logic [2:0] OP_LOWBIT = 3'd2;
  localparam logic [2:0] OP_LOWMSK = 3'd3;
  localparam logic [2:0] OP_LOWCLR = 3'd4;
  localparam logic [2:0] OP_TZERO  = 3'd5;

  logic [XLEN-1:0] keep_mask, a_eff, b_eff, a_dec;
  logic [XLEN-1:0] field_shift, field_mask, nxt_raw, nxt;
  logic [7:0]      fld_start, fld_len;
  logic [CW-1:0]   tz_cnt;

  assign keep_mask = narrow ? {{HALF{1'b0}}, {HALF{1'b1}}} : '1;
  assign a_eff     = opnd_a & keep_mask;
  assign b_eff     = opnd_b & keep_mask;
  assign a_dec     = a_eff - XLEN'(1);

  assign fld_start   = b_eff[7:0];
  assign fld_len     = b_eff[15:8];
  assign field_shift = a_eff >> fld_start;
  assign field_mask  = (int'(fld_len) >= XLEN) ? '1 : ((XLEN'(1) << fld_len) - XLEN'(1));

  always_comb begin
    tz_cnt = narrow ? CW'(HALF) : CW'(XLEN);
    for (int i = XLEN - 1; i >= 0; i--)
      if (a_eff[i]) tz_cnt = CW'(i);
  end

  always_comb begin
    case (op_sel)
      OP_ANDNOT: nxt_raw = ~a_eff & b_eff;
      OP_FIELD:  nxt_raw = field_shift & field_mask;
      OP_LOWBIT: nxt_raw = (-a_eff) & a_eff;
      OP_LOWMSK: nxt_raw = a_dec ^ a_eff;
      OP_LOWCLR: nxt_raw = a_dec & a_eff;
      OP_TZERO:  nxt_raw = XLEN'(tz_cnt);
      default:   nxt_raw = '0;
    endcase
  end

  assign nxt = nxt_raw & keep_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

module bitmanip_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [2:0]      op_sel,
  input logic            narrow,
  input logic [XLEN-1:0] result,
  input logic            out_valid
);
  localparam int HALF = XLEN / 2;

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_drops_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_result_held_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  assert_reset_clears_R12: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));
  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && narrow) |=> result[XLEN-1:HALF] == '0);
  assert_isolate_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 3'd2) |=> $onehot0(result));
  assert_tzcount_range_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 3'd5) |=> result <= XLEN);
  assert_unused_code_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel[2:1] == 2'b11) |=> result == '0);
endmodule

bind bitmanip_unit bitmanip_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
  .narrow(narrow), .result(result), .out_valid(out_valid)
);

// File: tb/test_bitmanip_unit.sv
module test_bitmanip_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic        narrow = 1'b0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic [63:0] result;
  logic        out_valid;

  int n_checks = 0;
  int n_fail   = 0;

  bitmanip_unit i_bitmanip_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .narrow(narrow),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .out_valid(out_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] model(input logic [2:0] op, input logic nw,
                                        input logic [63:0] a, input logic [63:0] b);
    int w = nw ? 32 : 64;
    int lo = -1;
    int st, ln;
    logic [63:0] aa = a, bb = b, r = '0;
    if (nw) begin aa[63:32] = '0; bb[63:32] = '0; end
    for (int i = w - 1; i >= 0; i--) if (aa[i]) lo = i;
    st = int'(bb[7:0]);
    ln = int'(bb[15:8]);
    case (op)
      3'd0: r = ~aa & bb;
      3'd1: for (int i = 0; i < 64; i++)
              if (i < ln && st + i < w) r[i] = aa[st + i];
      3'd2: if (lo >= 0) r[lo] = 1'b1;
      3'd3: begin
              int top = (lo >= 0) ? lo : w - 1;
              for (int i = 0; i <= top; i++) r[i] = 1'b1;
            end
      3'd4: begin r = aa; if (lo >= 0) r[lo] = 1'b0; end
      3'd5: r = (lo >= 0) ? 64'(lo) : 64'(w);
      default: r = '0;
    endcase
    if (nw) r[63:32] = '0;
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic run_op(input string tag, input logic [2:0] op, input logic nw,
                        input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    op_sel = op; narrow = nw; opnd_a = a; opnd_b = b; in_valid = 1'b1;
    @(posedge clk); #1;
    check({tag, " valid"}, {63'd0, out_valid}, 64'd1);
    check(tag, result, model(op, nw, a, b));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    check("R12 reset valid", {63'd0, out_valid}, 64'd0);
    check("R12 reset result", result, 64'd0);
    @(negedge clk); rst = 1'b0;

    run_op("R1 andnot", 3'd0, 1'b0, 64'hF0F0_1234_5678_9ABC, 64'hFFFF_0000_FFFF_0000);
    run_op("R2 extract mid", 3'd1, 1'b0, 64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_0000_0C08);
    run_op("R2 extract high ctl ignored", 3'd1, 1'b0, 64'hDEAD_BEEF_CAFE_F00D, 64'hFFFF_FFFF_ABCD_0C08);
    run_op("R2 extract len zero", 3'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0005);
    check("R2 extract len zero literal", result, 64'd0);
    run_op("R3 extract start 64", 3'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0840);
    check("R3 start 64 literal", result, 64'd0);
    run_op("R3 extract start 40 narrow", 3'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0828);
    check("R3 start 40 narrow literal", result, 64'd0);
    run_op("R4 extract truncate wide", 3'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_103C);
    check("R4 truncate wide literal", result, 64'h0000_0000_0000_000F);
    run_op("R4 extract truncate narrow", 3'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_FF1C);
    check("R4 truncate narrow literal", result, 64'h0000_0000_0000_000F);
    run_op("R5 isolate", 3'd2, 1'b0, 64'h0000_0100_0000_0000, 64'd0);
    run_op("R5 isolate zero", 3'd2, 1'b0, 64'd0, 64'd0);
    run_op("R6 mask", 3'd3, 1'b0, 64'hA000_0000_0000_0010, 64'd0);
    run_op("R6 mask zero wide", 3'd3, 1'b0, 64'd0, 64'd0);
    check("R6 mask zero wide literal", result, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op("R6 mask zero narrow", 3'd3, 1'b1, 64'hFFFF_0000_0000_0000, 64'd0);
    check("R6 mask zero narrow literal", result, 64'h0000_0000_FFFF_FFFF);
    run_op("R7 clear lowest", 3'd4, 1'b0, 64'h8000_0000_0000_0600, 64'd0);
    run_op("R8 tzcount", 3'd5, 1'b0, 64'h8000_0000_0000_0000, 64'd0);
    check("R8 tzcount top literal", result, 64'd63);
    run_op("R8 tzcount zero wide", 3'd5, 1'b0, 64'd0, 64'd0);
    check("R8 tzcount zero wide literal", result, 64'd64);
    run_op("R8 tzcount zero narrow", 3'd5, 1'b1, 64'h1000_0000_0000_0000, 64'd0);
    check("R8 tzcount zero narrow literal", result, 64'd32);
    run_op("R9 code 6", 3'd6, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op("R9 code 7", 3'd7, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'h5555_5555_5555_5555);
    run_op("R10 narrow andnot", 3'd0, 1'b1, 64'h0000_0000_0000_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R10 narrow andnot literal", result, 64'h0000_0000_FFFF_0000);

    held = result;
    @(negedge clk);
    in_valid = 1'b0; op_sel = 3'd0; opnd_a = '0; opnd_b = '1; narrow = 1'b0;
    @(posedge clk); #1;
    check("R11 valid low", {63'd0, out_valid}, 64'd0);
    check("R11 result held", result, held);

    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; op_sel = 3'd3; opnd_a = '0;
    @(posedge clk); #1;
    check("R12 reset over valid", {63'd0, out_valid}, 64'd0);
    check("R12 reset over valid result", result, 64'd0);
    @(negedge clk); rst = 1'b0;

    for (int k = 0; k < 600; k++) begin
      logic [63:0] ra, rb;
      logic [2:0]  rop;
      logic        rn;
      ra  = {$urandom, $urandom};
      rb  = {$urandom, $urandom};
      rop = 3'($urandom_range(0, 7));
      rn  = 1'($urandom);
      if (rop == 3'd1) begin
        rb[7:0]  = 8'($urandom_range(0, 80));
        rb[15:8] = 8'($urandom_range(0, 80));
      end
      if ($urandom_range(0, 3) == 0) ra = ra << $urandom_range(0, 63);
      run_op("R1-R10 random", rop, rn, ra, rb);
    end
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
    finish_run();
  end
endmodule